// File: doc/BRIEF.md
# Prioritising Interrupt Controller with Register Bus

This block gathers up to 32 interrupt request lines into one latched status word. A processor programs it and services it over a simple word-addressed register bus. For each line, software chooses the active level and whether a level or an edge sets the status bit. Software also chooses whether the line is enabled, and whether an enabled pending request drives the normal or the critical interrupt output. Status bits are cleared by writing ones to one register and forced by writing ones to another, so a read-modify-write is never needed.

For dispatch, the block offers a masked status view and a ready-made vector word. The vector word is a programmable base plus four times the number of the winning source. The winner is the highest-priority pending enabled source, and the direction of priority is chosen by one configuration bit. Reads are combinational from the address. Writes and input sampling take effect at the next rising clock edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it, every register reads 0 and both interrupt outputs are low.
- R2: Source i always occupies bit (31 - i) of every per-source register, so source 0 is bit 31 and source 31 is bit 0.
- R3: The word map is as follows. Byte offset 0x00 is status. Writing a 1 to a status bit clears that bit, and writing 0 leaves it alone. Offset 0x04 is status-set: writing a 1 forces the bit to 1, and the register reads as 0.
- R4: The polarity register is at 0x10, where 1 means active high and 0 means active low. In level mode (trigger bit 0, register at 0x14), a status bit is set on every clock edge at which its input is at the active level. A clear does not win while that level persists.
- R5: In edge mode (trigger bit 1), a status bit is set when the input moves into its active level compared with its value one clock earlier. A clear written in the same cycle as such an edge leaves the bit set.
- R6: The masked view at 0x18 reads status AND enable, with the enable register at 0x08. Writes to 0x18 are ignored.
- R7: With the critical register at 0x0C, `irq_crit` is high exactly when some masked bit with its critical bit set is 1. `irq_norm` is high exactly when some masked bit with its critical bit clear is 1.
- R8: The vector word at 0x1C reads base + 4 × (number of the winning source). With no masked bit set, it reads the base alone. Writes to it are ignored.
- R9: The configuration at 0x20 holds the base in bits 31:2 (bits 1:0 of the base are zero) and the order in bit 0. Order 0 makes source 31 the highest priority, and order 1 makes source 0 the highest. Bit 1 reads 0.
- R10: Writes and input changes show in reads and outputs after the next rising clock edge. Unmapped or misaligned addresses read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, bit b carries source 31-b |
| bus_addr | input | 6 | Byte address of the register word |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
The request lines receive sparse random toggles in three phases: all level-triggered, all edge-triggered, and mixed. Random polarities run throughout. The level phase separates a persistent level that overrides a clear from a status that was only set once. The edge phase separates a transition from a steady active level. Frequent all-ones clears land on the same cycle as fresh edges and reveal whether a clear wrongly beats a coincident edge. Directed writes to the set register at sources 0 and 31 under both order settings expose a swapped bit mapping or a reversed priority scan in the vector word.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [3:0] {
    W_STAT = 4'd0,
    W_SET  = 4'd1,
    W_EN   = 4'd2,
    W_CRIT = 4'd3,
    W_POL  = 4'd4,
    W_TRIG = 4'd5,
    W_MASK = 4'd6,
    W_VEC  = 4'd7,
    W_VCFG = 4'd8
  } reg_word_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] crit_q,
  output logic [NSRC-1:0] pol_q,
  output logic [NSRC-1:0] trig_q,
  output logic [DW-1:0]   vbase_q,
  output logic            order_q,
  output logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] set_mask,
  output logic [AW-3:0]   word_sel,
  output logic            word_ok
);
  localparam int unsigned WW = AW - 2;

  logic wr_ok;
  logic unused_vcfg_bit1;

  assign word_sel = bus_addr[AW-1:2];
  assign word_ok  = (bus_addr[1:0] == 2'b00);
  assign wr_ok    = bus_we && word_ok;
  assign unused_vcfg_bit1 = bus_wdata[1];

  assign clr_mask = (wr_ok && word_sel == WW'(W_STAT)) ? bus_wdata[NSRC-1:0] : '0;
  assign set_mask = (wr_ok && word_sel == WW'(W_SET))  ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      crit_q  <= '0;
      pol_q   <= '0;
      trig_q  <= '0;
      vbase_q <= '0;
      order_q <= 1'b0;
    end else if (wr_ok) begin
      case (word_sel)
        WW'(W_EN):   en_q   <= bus_wdata[NSRC-1:0];
        WW'(W_CRIT): crit_q <= bus_wdata[NSRC-1:0];
        WW'(W_POL):  pol_q  <= bus_wdata[NSRC-1:0];
        WW'(W_TRIG): trig_q <= bus_wdata[NSRC-1:0];
        WW'(W_VCFG): begin
          vbase_q <= {bus_wdata[DW-1:2], 2'b00};
          order_q <= bus_wdata[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] pol_q,
  input  logic [NSRC-1:0] trig_q,
  input  logic [NSRC-1:0] clr_mask,
  input  logic [NSRC-1:0] set_mask,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] lvl_hit,
  output logic [NSRC-1:0] edge_hit
);
  logic [NSRC-1:0] prev_q;

  for (genvar b = 0; b < NSRC; b++) begin : g_cell
    logic act_now;
    logic act_prev;
    logic st_next;

    assign act_now     = ~(irq_in[b] ^ pol_q[b]);
    assign act_prev    = ~(prev_q[b] ^ pol_q[b]);
    assign lvl_hit[b]  = act_now & ~trig_q[b];
    assign edge_hit[b] = act_now & ~act_prev & trig_q[b];
    assign st_next     = lvl_hit[b] | edge_hit[b] | set_mask[b] |
                         (status_q[b] & ~clr_mask[b]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[b]   <= 1'b0;
        status_q[b] <= 1'b0;
      end else begin
        prev_q[b]   <= irq_in[b];
        status_q[b] <= st_next;
      end
    end
  end
endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned DW   = 32
) (
  input  logic [NSRC-1:0] masked,
  input  logic            order_q,
  input  logic [DW-1:0]   vbase_q,
  output logic [DW-1:0]   vector,
  output logic            any_pend
);
  localparam int unsigned IDXW = $clog2(NSRC);

  logic [IDXW-1:0] lo_bit;
  logic [IDXW-1:0] hi_bit;
  logic [IDXW-1:0] win_bit;
  logic [IDXW-1:0] win_src;
  logic            lo_found;
  logic            hi_found;

  always_comb begin
    lo_bit   = '0;
    lo_found = 1'b0;
    for (int b = 0; b < int'(NSRC); b++) begin
      if (masked[b] && !lo_found) begin
        lo_bit   = IDXW'(b);
        lo_found = 1'b1;
      end
    end
  end

  always_comb begin
    hi_bit   = '0;
    hi_found = 1'b0;
    for (int b = int'(NSRC) - 1; b >= 0; b--) begin
      if (masked[b] && !hi_found) begin
        hi_bit   = IDXW'(b);
        hi_found = 1'b1;
      end
    end
  end

  assign any_pend = lo_found;
  assign win_bit  = order_q ? hi_bit : lo_bit;
  assign win_src  = IDXW'(NSRC - 1) - win_bit;
  assign vector   = any_pend ? (vbase_q + (DW'(win_src) << 2)) : vbase_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_norm,
  output logic            irq_crit
);
  localparam int unsigned WW = AW - 2;

  logic [NSRC-1:0] en_q, crit_q, pol_q, trig_q;
  logic [NSRC-1:0] clr_mask, set_mask;
  logic [NSRC-1:0] status_q, lvl_hit, edge_hit, masked;
  logic [DW-1:0]   vbase_q, vector;
  logic            order_q, any_pend;
  logic [WW-1:0]   word_sel;
  logic            word_ok;

  irq_cfg_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q), .crit_q(crit_q), .pol_q(pol_q),
    .trig_q(trig_q), .vbase_q(vbase_q), .order_q(order_q),
    .clr_mask(clr_mask), .set_mask(set_mask), .word_sel(word_sel),
    .word_ok(word_ok)
  );

  irq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol_q(pol_q),
    .trig_q(trig_q), .clr_mask(clr_mask), .set_mask(set_mask),
    .status_q(status_q), .lvl_hit(lvl_hit), .edge_hit(edge_hit)
  );

  assign masked   = status_q & en_q;
  assign irq_norm = |(masked & ~crit_q);
  assign irq_crit = |(masked & crit_q);

  irq_vec_pick #(.NSRC(NSRC), .DW(DW)) u_pick (
    .masked(masked), .order_q(order_q), .vbase_q(vbase_q),
    .vector(vector), .any_pend(any_pend)
  );

  always_comb begin
    bus_rdata = '0;
    if (word_ok) begin
      case (word_sel)
        WW'(W_STAT): bus_rdata = DW'(status_q);
        WW'(W_EN):   bus_rdata = DW'(en_q);
        WW'(W_CRIT): bus_rdata = DW'(crit_q);
        WW'(W_POL):  bus_rdata = DW'(pol_q);
        WW'(W_TRIG): bus_rdata = DW'(trig_q);
        WW'(W_MASK): bus_rdata = DW'(masked);
        WW'(W_VEC):  bus_rdata = vector;
        WW'(W_VCFG): bus_rdata = vbase_q | DW'(order_q);
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] crit_q,
  input logic [NSRC-1:0] lvl_hit,
  input logic [NSRC-1:0] edge_hit,
  input logic            irq_norm,
  input logic            irq_crit
);
  logic wr_clr, wr_set;
  assign wr_clr = bus_we && bus_addr == AW'(0);
  assign wr_set = bus_we && bus_addr == AW'(4);

  p_set_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((status_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((status_q & $past(bus_wdata[NSRC-1:0]) & ~$past(lvl_hit | edge_hit)) == '0));

  p_level_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_hit) |=> ((status_q & $past(lvl_hit)) == $past(lvl_hit)));

  p_edge_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_q) == '0) |-> (!irq_norm && !irq_crit));

  p_crit_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> ((status_q & en_q & crit_q) != '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .status_q(status_q), .en_q(en_q), .crit_q(crit_q),
  .lvl_hit(lvl_hit), .edge_hit(edge_hit), .irq_norm(irq_norm),
  .irq_crit(irq_crit)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_norm, irq_crit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state, indexed by source number
  bit          m_st [0:31];
  bit          m_en [0:31];
  bit          m_cr [0:31];
  bit          m_po [0:31];
  bit          m_tr [0:31];
  logic [31:0] m_prev;
  logic [29:0] m_base;
  bit          m_ord;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  function automatic logic [31:0] pack(input int which);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      case (which)
        0: r[31-i] = m_st[i];
        1: r[31-i] = m_en[i];
        2: r[31-i] = m_cr[i];
        3: r[31-i] = m_po[i];
        4: r[31-i] = m_tr[i];
        default: r[31-i] = m_st[i] & m_en[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_vector();
    int win = -1;
    if (m_ord) begin
      for (int i = 31; i >= 0; i--) if (m_st[i] && m_en[i]) win = i;
    end else begin
      for (int i = 0; i < 32; i++) if (m_st[i] && m_en[i]) win = i;
    end
    if (win < 0) return {m_base, 2'b00};
    return {m_base, 2'b00} + 32'(win * 4);
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    case (a)
      6'h00: return pack(0);
      6'h08: return pack(1);
      6'h0C: return pack(2);
      6'h10: return pack(3);
      6'h14: return pack(4);
      6'h18: return pack(5);
      6'h1C: return exp_vector();
      6'h20: return {m_base, 1'b0, m_ord};
      default: return 32'h0;   // 0x04 and unmapped read 0
    endcase
  endfunction

  // cycle reference model (R2 R3 R4 R5 R9 R10)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m_st[i] = 0; m_en[i] = 0; m_cr[i] = 0; m_po[i] = 0; m_tr[i] = 0;
      end
      m_prev = '0; m_base = '0; m_ord = 0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        bit act, pact, clr, setb, hit;
        act  = (irq_in[31-i] == m_po[i]);
        pact = (m_prev[31-i] == m_po[i]);
        clr  = bus_we && bus_addr == 6'h00 && bus_wdata[31-i];
        setb = bus_we && bus_addr == 6'h04 && bus_wdata[31-i];
        hit  = m_tr[i] ? (act && !pact) : act;
        m_st[i] = hit || (m_st[i] && !clr) || setb;
      end
      m_prev = irq_in;
      if (bus_we) begin
        for (int i = 0; i < 32; i++) begin
          case (bus_addr)
            6'h08: m_en[i] = bus_wdata[31-i];
            6'h0C: m_cr[i] = bus_wdata[31-i];
            6'h10: m_po[i] = bus_wdata[31-i];
            6'h14: m_tr[i] = bus_wdata[31-i];
            default: ;
          endcase
        end
        if (bus_addr == 6'h20) begin
          m_base = bus_wdata[31:2];
          m_ord  = bus_wdata[0];
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h t=%0t", tag, bus_addr, act, exp, $time);
    end
  endtask

  task automatic compare();
    string tag;
    bit en_n = 0, en_c = 0;
    case (bus_addr)
      6'h00: tag = "R2 R3 R4 R5 status";
      6'h04: tag = "R3 set reads zero";
      6'h08, 6'h0C, 6'h10, 6'h14: tag = "R2 R10 config";
      6'h18: tag = "R6 masked";
      6'h1C: tag = "R8 R9 vector";
      6'h20: tag = "R9 vcfg";
      default: tag = "R10 unmapped";
    endcase
    check(tag, bus_rdata, exp_read(bus_addr));
    for (int i = 0; i < 32; i++) begin
      if (m_st[i] && m_en[i] && !m_cr[i]) en_n = 1;
      if (m_st[i] && m_en[i] && m_cr[i])  en_c = 1;
    end
    check("R7 normal output", {31'b0, irq_norm}, {31'b0, en_n});
    check("R7 critical output", {31'b0, irq_crit}, {31'b0, en_c});
  endtask

  // drive at a falling edge, compare at the next falling edge (R10)
  task automatic step(input logic we, input logic [5:0] a, input logic [31:0] d,
                      input logic [31:0] irq);
    bus_we = we; bus_addr = a; bus_wdata = d; irq_in = irq;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [5:0] pick_addr();
    logic [5:0] tbl [0:9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10,
                              6'h14, 6'h18, 6'h1C, 6'h20, 6'h24};
    return tbl[$urandom_range(0, 9)];
  endfunction

  initial begin
    repeat (CLK_PERIOD * 200000 / 1ns) #1ns;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] irq = '0;
    // R1: reset state on every readable word
    repeat (3) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      bus_addr = 6'(k * 4);
      #1ns;
      check("R1 reset read", bus_rdata, 32'h0);
    end
    check("R1 reset outputs", {30'b0, irq_norm, irq_crit}, 32'h0);
    bus_addr = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // directed: mapping and order at the extremes (R2 R8 R9)
    step(1, 6'h08, 32'hFFFF_FFFF, 0);
    step(1, 6'h10, 32'hFFFF_FFFF, 0);
    step(1, 6'h14, 32'hFFFF_FFFF, 0);
    step(1, 6'h00, 32'hFFFF_FFFF, 0);
    step(1, 6'h20, 32'h0000_1002, 0);
    step(0, 6'h1C, 0, 0);                 // R8 base alone when nothing pending
    step(1, 6'h04, 32'h8000_0000, 0);     // source 0
    step(1, 6'h04, 32'h0000_0001, 0);     // source 31
    step(0, 6'h1C, 0, 0);                 // R9 order 0 picks source 31
    step(1, 6'h20, 32'h0000_1001, 0);
    step(0, 6'h1C, 0, 0);                 // R9 order 1 picks source 0
    step(1, 6'h0C, 32'h8000_0000, 0);
    step(0, 6'h18, 0, 0);                 // R6 R7 both outputs
    step(1, 6'h18, 32'h0, 0);             // R6 write ignored
    step(0, 6'h18, 0, 0);
    step(1, 6'h00, 32'hFFFF_FFFF, 32'h0000_0100); // R5 edge with clear
    step(0, 6'h00, 0, 32'h0000_0100);

    // random phases: level, edge, mixed
    for (int ph = 0; ph < 3; ph++) begin
      for (int c = 0; c < 1200; c++) begin
        logic        we;
        logic [5:0]  a;
        logic [31:0] d;
        irq ^= ($urandom & $urandom & $urandom);
        we = ($urandom_range(0, 3) == 0);
        a  = pick_addr();
        d  = $urandom;
        if (a == 6'h08) d = d | $urandom;
        if (a == 6'h00 && $urandom_range(0, 1) == 0) d = 32'hFFFF_FFFF;
        if (a == 6'h14) d = (ph == 0) ? 32'h0 : (ph == 1) ? 32'hFFFF_FFFF : d;
        step(we, a, d, irq);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule